// File: doc/BRIEF.md
# Interrupt Priority Acceptance Unit

This unit decides, at each instruction boundary, whether the processor should stop and service a pending request. It watches two kinds of request source. Internal error sources always win and carry fixed vector addresses. Device sources each supply a 3-bit priority level and a vector address that is set through a configuration input, much like jumpers on a board.

A device request is taken only when its level is strictly above the execution priority held in the status word. When the unit takes a request, it raises a one-clock accept pulse together with a registered vector address. In the same cycle it sends a one-hot acknowledge to the winning source, which must then drop its request. Pushing state onto the stack and fetching the vector happen elsewhere.

Top module: `irq_accept`

## Requirements
- R1: After reset, `take_o` is 0, `vec_o` is 0, and both acknowledge buses are all zeros.
- R2: A device request is eligible only when its 3-bit level is strictly greater than `psw_i[7:5]`. A request at equal or lower level is not taken.
- R3: A request is taken only on a clock edge where `boundary_i` is high. Without that strobe, no accept occurs however long a request is held.
- R4: Among eligible device requests, the one with the highest level wins.
- R5: When eligible device requests share the highest level, the one with the lowest index wins.
- R6: Any active error request outranks every device request, at any value of `psw_i[7:5]`. Among error requests the lowest index wins. Error index k has vector 16'o004 + 4*k.
- R7: When device i wins, `vec_o` equals `dev_vec_i[16*i+15:16*i]`. Device i's level is `dev_pri_i[3*i+2:3*i]`.
- R8: `take_o` rises on the clock edge that samples the strobe, stays high for exactly one cycle, and `vec_o` is registered at that edge.
- R9: While `take_o` is high, exactly one acknowledge bit is set, and it belongs to the winner. Bit i of `dev_ack_o` belongs to device i, and bit k of `err_ack_o` belongs to error source k. All acknowledge bits are 0 otherwise.
- R10: A strobe with no eligible request leaves `take_o` low and `vec_o` unchanged.
- R11: Changing `psw_i[7:5]` between boundaries changes acceptance accordingly. Lowering it makes a previously refused request eligible.
- R12: A strobe that arrives in the cycle `take_o` is high is not evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| boundary_i | input | 1 | Instruction-boundary strobe |
| psw_i | input | 16 | Processor status word; bits 7:5 hold the execution priority |
| err_req_i | input | 2 | Internal error request lines |
| dev_req_i | input | 4 | Device request lines |
| dev_pri_i | input | 12 | Packed 3-bit device levels |
| dev_vec_i | input | 64 | Packed 16-bit device vector addresses |
| take_o | output | 1 | One-cycle accept pulse |
| vec_o | output | 16 | Vector address of the accepted request |
| err_ack_o | output | 2 | Acknowledge to the winning error source |
| dev_ack_o | output | 4 | Acknowledge to the winning device source |

## Verification
A wrong winner index inside the arbiter shows up one clock after the strobe. It appears both as an unexpected `vec_o` value and as the acknowledge on the wrong line, so ties and mixed levels are driven on purpose. A broken priority compare, for example greater-or-equal instead of greater, gives an accept pulse at a strobe that should have been refused. A stuck accept register shows as a pulse longer than one cycle, or as a second accept from a strobe during the pulse. Vector corruption in the hold path appears at the next empty boundary as a changed `vec_o`.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int PRI_W = 3;
  localparam int VEC_W = 16;
  localparam int PSW_W = 16;
  localparam int PSW_PRI_LSB = 5;

  typedef logic [PRI_W-1:0] pri_t;
  typedef logic [VEC_W-1:0] vec_t;

  function automatic pri_t psw_level(input logic [PSW_W-1:0] w);
    return w[PSW_PRI_LSB +: PRI_W];
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/irq_dev_arb.sv
module irq_dev_arb
  import irq_accept_pkg::*;
#(
  parameter int N_DEV = 4,
  localparam int DEV_IW = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic [N_DEV-1:0]       req_i,
  input  logic [N_DEV*PRI_W-1:0] pri_i,
  input  pri_t                   cur_pri_i,
  output logic                   hit_o,
  output logic [DEV_IW-1:0]      idx_o,
  output pri_t                   pri_o
);
  pri_t             lvl [N_DEV];
  logic [N_DEV-1:0] elig;

  for (genvar g = 0; g < N_DEV; g++) begin : g_qual
    assign lvl[g]  = pri_i[g*PRI_W +: PRI_W];
    assign elig[g] = req_i[g] && (lvl[g] > cur_pri_i);
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    pri_o = '0;
    for (int i = 0; i < N_DEV; i++) begin
      if (elig[i] && (!hit_o || (lvl[i] > pri_o))) begin
        hit_o = 1'b1;
        idx_o = DEV_IW'(i);
        pri_o = lvl[i];
      end
    end
  end
endmodule

// File: rtl/irq_err_sel.sv
module irq_err_sel #(
  parameter int N_ERR = 2,
  localparam int ERR_IW = (N_ERR > 1) ? $clog2(N_ERR) : 1
) (
  input  logic [N_ERR-1:0]  req_i,
  output logic              hit_o,
  output logic [ERR_IW-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N_ERR - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        idx_o = ERR_IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_accept_reg.sv
module irq_accept_reg
  import irq_accept_pkg::*;
#(
  parameter int N_SRC = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary_i,
  input  logic             hit_i,
  input  vec_t             vec_i,
  input  logic [N_SRC-1:0] ack_i,
  output logic             take_o,
  output vec_t             vec_o,
  output logic [N_SRC-1:0] ack_o
);
  logic             take_q, take_d;
  vec_t             vec_q, vec_d;
  logic [N_SRC-1:0] ack_q, ack_d;
  logic             eval;

  assign eval = boundary_i && !take_q && hit_i;

  always_comb begin
    take_d = eval;
    vec_d  = eval ? vec_i : vec_q;
    ack_d  = eval ? ack_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      vec_q  <= '0;
      ack_q  <= '0;
    end else begin
      take_q <= take_d;
      ack_q  <= ack_d;
      if (eval) vec_q <= vec_d;
    end
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;
  assign ack_o  = ack_q;

  AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |=> !take_q); // R8
  AST_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary_i |=> !take_q); // R3
  AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_q |-> $stable(vec_q)); // R10
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> $countones(ack_q) == 1); // R9
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take_q |-> ack_q == '0); // R9
endmodule

// File: rtl/irq_accept.sv
module irq_accept
  import irq_accept_pkg::*;
#(
  parameter int   N_DEV        = 4,
  parameter int   N_ERR        = 2,
  parameter vec_t ERR_VEC_BASE = 16'o004,
  parameter vec_t ERR_VEC_STEP = 16'o004
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   boundary_i,
  input  logic [PSW_W-1:0]       psw_i,
  input  logic [N_ERR-1:0]       err_req_i,
  input  logic [N_DEV-1:0]       dev_req_i,
  input  logic [N_DEV*PRI_W-1:0] dev_pri_i,
  input  logic [N_DEV*VEC_W-1:0] dev_vec_i,
  output logic                   take_o,
  output logic [VEC_W-1:0]       vec_o,
  output logic [N_ERR-1:0]       err_ack_o,
  output logic [N_DEV-1:0]       dev_ack_o
);
  localparam int DEV_IW = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam int ERR_IW = (N_ERR > 1) ? $clog2(N_ERR) : 1;
  localparam int N_SRC  = N_ERR + N_DEV;

  logic              rst_s;
  pri_t              cur_pri;
  logic              dev_hit, err_hit, any_hit;
  logic [DEV_IW-1:0] dev_idx;
  logic [ERR_IW-1:0] err_idx;
  pri_t              dev_lvl;
  vec_t              win_vec;
  logic [N_DEV-1:0]  dev_oh;
  logic [N_ERR-1:0]  err_oh;
  logic [N_SRC-1:0]  ack_next, ack_q;

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s));

  assign cur_pri = psw_level(psw_i);

  irq_dev_arb #(.N_DEV(N_DEV)) u_dev (
    .req_i(dev_req_i), .pri_i(dev_pri_i), .cur_pri_i(cur_pri),
    .hit_o(dev_hit), .idx_o(dev_idx), .pri_o(dev_lvl)
  );

  irq_err_sel #(.N_ERR(N_ERR)) u_err (
    .req_i(err_req_i), .hit_o(err_hit), .idx_o(err_idx)
  );

  for (genvar g = 0; g < N_DEV; g++) begin : g_dev_oh
    assign dev_oh[g] = !err_hit && dev_hit && (dev_idx == DEV_IW'(g));
  end
  for (genvar g = 0; g < N_ERR; g++) begin : g_err_oh
    assign err_oh[g] = err_hit && (err_idx == ERR_IW'(g));
  end

  always_comb begin
    if (err_hit) win_vec = ERR_VEC_BASE + ERR_VEC_STEP * VEC_W'(err_idx);
    else         win_vec = dev_vec_i[dev_idx*VEC_W +: VEC_W];
  end

  assign any_hit  = err_hit || dev_hit;
  assign ack_next = {err_oh, dev_oh};

  irq_accept_reg #(.N_SRC(N_SRC)) u_reg (
    .clk(clk), .rst_n(rst_s), .boundary_i(boundary_i), .hit_i(any_hit),
    .vec_i(win_vec), .ack_i(ack_next),
    .take_o(take_o), .vec_o(vec_o), .ack_o(ack_q)
  );

  assign err_ack_o = ack_q[N_SRC-1 -: N_ERR];
  assign dev_ack_o = ack_q[N_DEV-1:0];

  AST_STRICT_LEVEL: assert property (@(posedge clk) disable iff (!rst_s)
    (take_o && (|dev_ack_o)) |-> ($past(dev_lvl) > $past(cur_pri))); // R2
  AST_ERR_FIRST: assert property (@(posedge clk) disable iff (!rst_s)
    (take_o && (|dev_ack_o)) |-> ($past(err_req_i) == '0)); // R6
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_s)
    !((|err_ack_o) && (|dev_ack_o))); // R9
endmodule

// File: tb/tb_irq_accept.sv
`timescale 1ns/1ps
module tb_irq_accept;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        boundary;
  logic [15:0] psw;
  logic [1:0]  err_req;
  logic [3:0]  dev_req;
  logic [11:0] dev_pri;
  logic [63:0] dev_vec;
  logic        take;
  logic [15:0] vec;
  logic [1:0]  err_ack;
  logic [3:0]  dev_ack;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  irq_accept dut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary), .psw_i(psw),
    .err_req_i(err_req), .dev_req_i(dev_req), .dev_pri_i(dev_pri),
    .dev_vec_i(dev_vec), .take_o(take), .vec_o(vec),
    .err_ack_o(err_ack), .dev_ack_o(dev_ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_dev(input int i, input logic r, input logic [2:0] p);
    dev_req[i] = r;
    dev_pri[3*i +: 3] = p;
  endtask

  task automatic clear_reqs();
    dev_req = '0;
    err_req = '0;
  endtask

  // strobe one cycle; returns at the negedge after the sampling edge
  task automatic strobe();
    @(negedge clk) boundary = 1'b1;
    @(negedge clk) boundary = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 take", take, 0);
    chk("R1 vec", vec, 0);
    chk("R1 ack", {err_ack, dev_ack}, 0);
  endtask

  task automatic t_strict();
    psw = 16'h0060; // level 3
    set_dev(0, 1'b1, 3'd3);
    strobe();
    chk("R2 equal refused", take, 0);
    chk("R10 vec held", vec, 0);
    set_dev(0, 1'b1, 3'd4);
    strobe();
    chk("R2 greater taken", take, 1);
    chk("R7 dev0 vec", vec, 16'o070);
    chk("R9 ack dev0", {err_ack, dev_ack}, 6'b00_0001);
    clear_reqs();
    @(negedge clk);
    chk("R8 pulse one cycle", take, 0);
    chk("R9 ack cleared", dev_ack, 0);
  endtask

  task automatic t_boundary();
    psw = 16'h0000;
    set_dev(3, 1'b1, 3'd7);
    repeat (4) @(negedge clk);
    chk("R3 no strobe no take", take, 0);
    strobe();
    chk("R3 strobe takes", take, 1);
    chk("R7 dev3 vec", vec, 16'o310);
    clear_reqs();
    @(negedge clk);
  endtask

  task automatic t_highest();
    psw = 16'h0020; // level 1
    set_dev(1, 1'b1, 3'd2);
    set_dev(2, 1'b1, 3'd5);
    set_dev(3, 1'b1, 3'd4);
    strobe();
    chk("R4 highest ack", dev_ack, 4'b0100);
    chk("R4 highest vec", vec, 16'o300);
    clear_reqs();
    @(negedge clk);
  endtask

  task automatic t_tie();
    psw = 16'h0000;
    set_dev(1, 1'b1, 3'd6);
    set_dev(3, 1'b1, 3'd6);
    set_dev(0, 1'b1, 3'd2);
    strobe();
    chk("R5 tie lowest index", dev_ack, 4'b0010);
    chk("R5 tie vec", vec, 16'o060);
    clear_reqs();
    @(negedge clk);
  endtask

  task automatic t_err();
    psw = 16'h00E0; // level 7
    set_dev(2, 1'b1, 3'd7);
    err_req = 2'b10;
    strobe();
    chk("R6 err1 taken at level 7", take, 1);
    chk("R6 err1 vec", vec, 16'o010);
    chk("R6 err1 ack", {err_ack, dev_ack}, 6'b10_0000);
    clear_reqs();
    @(negedge clk);
    psw = 16'h0000;
    err_req = 2'b11;
    set_dev(0, 1'b1, 3'd7);
    strobe();
    chk("R6 err0 beats all", {err_ack, dev_ack}, 6'b01_0000);
    chk("R6 err0 vec", vec, 16'o004);
    clear_reqs();
    @(negedge clk);
  endtask

  task automatic t_hold();
    psw = 16'h00A0; // level 5
    set_dev(1, 1'b1, 3'd5);
    strobe();
    chk("R10 no take", take, 0);
    chk("R10 vec unchanged", vec, 16'o004);
    chk("R10 no ack", {err_ack, dev_ack}, 0);
    clear_reqs();
  endtask

  task automatic t_psw();
    psw = 16'h00A0; // level 5
    set_dev(2, 1'b1, 3'd3);
    strobe();
    chk("R11 refused at level 5", take, 0);
    psw = 16'h0020; // level 1
    strobe();
    chk("R11 taken at level 1", take, 1);
    chk("R11 vec", vec, 16'o300);
    clear_reqs();
    @(negedge clk);
  endtask

  task automatic t_busy();
    psw = 16'h0000;
    set_dev(0, 1'b1, 3'd1);
    @(negedge clk) boundary = 1'b1;
    @(negedge clk);
    chk("R12 first strobe taken", take, 1);
    @(negedge clk) boundary = 1'b0;
    chk("R12 strobe during pulse ignored", take, 0);
    clear_reqs();
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; boundary = 1'b0; psw = '0; err_req = '0; dev_req = '0;
    dev_pri = '0;
    dev_vec = {16'o310, 16'o300, 16'o060, 16'o070};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_strict();
    t_boundary();
    t_highest();
    t_tie();
    t_err();
    t_hold();
    t_psw();
    t_busy();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule